// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

This block is a wide synchronous binary counter built from a chain of identical 4-bit stages. Each stage counts modulo 16. It has a 4-bit preset word, an active-low clear, an active-low load and two count enables. The parallel enable goes to every stage. The trickle enable passes down the chain through the terminal-count signal of each stage. A stage's terminal count is high when the stage holds all ones and its trickle enable is high. Because of this, the chain increments as one wide counter with no ripple through registers: stage k sees the carry out of stage k-1 in the same cycle.

Every control acts on the rising clock edge. The priority is fixed: reset first, then clear, then load, then count, then hold. When the divider-mode input is high, the final terminal count also forces a load. The chain therefore reloads its preset on the edge after it reaches all ones, and it becomes a programmable divider with a period of 16^N minus the preset.

Top module: `casc_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes 0, whatever the other inputs are.
- R2: When `rst` is low and `clr_n` is low at a rising edge, `count` becomes 0, whatever `load_n`, `div_en`, the enables or `preset` are.
- R3: When `rst` is low, `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `preset`, whatever both enables are.
- R4: When `rst` is low, `clr_n` and `load_n` are high, no divider reload applies, and both `en_par` and `en_trk` are high, `count` increments by one modulo 16^NUM_STAGES. The carry moves across every 4-bit stage boundary in the same edge.
- R5: Under the same conditions as R4, if either `en_par` or `en_trk` is low, `count` keeps its value.
- R6: `term_cnt` is a combinational output. It is high exactly when `count` is all ones and `en_trk` is high.
- R7: When `div_en` is high and `term_cnt` is high at an edge where `clr_n` is high, `count` reloads `preset`. With both enables held high, `term_cnt` then pulses once every 16^NUM_STAGES minus `preset` cycles.
- R8: In divider mode a low `clr_n` still wins over the terminal-count reload, and `count` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| clr_n | input | 1 | Synchronous clear, active low. |
| load_n | input | 1 | Synchronous preset load, active low. |
| div_en | input | 1 | Divider mode: the final terminal count forces a reload. |
| en_par | input | 1 | Parallel count enable, shared by all stages. |
| en_trk | input | 1 | Trickle count enable into the first stage. |
| preset | input | 4*NUM_STAGES | Parallel preset word. |
| count | output | 4*NUM_STAGES | Registered count. |
| term_cnt | output | 1 | Terminal count of the last stage. |

## Verification
The bench builds the block with NUM_STAGES = 3, which gives a 12-bit count. At that width a full wrap from 0xFFF to 0 takes only 4096 cycles, and carries cross two stage boundaries. A divider run with preset 0 takes the whole 4096-cycle period, and one with preset 0xFFF gives a period of a single cycle. Both fit easily in one run. At this depth, random stimulus also often lands on all-ones values of the lower stages, where the trickle chain matters.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  localparam int STAGE_W = 4;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } stage_op_e;

  // Fixed priority: clear, then load, then count, then hold.
  function automatic stage_op_e decode_op(input logic clr_n, input logic load_n,
                                          input logic en_par, input logic en_trk);
    stage_op_e op;
    if (!clr_n)                op = OP_CLEAR;
    else if (!load_n)          op = OP_LOAD;
    else if (en_par && en_trk) op = OP_COUNT;
    else                       op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = STAGE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  stage_op_e op;

  always_comb begin
    op = decode_op(clr_n, load_n, en_par, en_trk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: q <= '0;
        OP_LOAD:  q <= din;
        OP_COUNT: q <= q + ONE;
        default:  q <= q;
      endcase
    end
  end

  assign tc = en_trk && (q == ALL_ONES);

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> q == '0); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> q == '0); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> q == $past(din)); // R3
  AST_STAGE_INC: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_par && en_trk) |=> q == $past(q) + ONE); // R4
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q)); // R5
  AST_TC_FULL: assert property (@(posedge clk) disable iff (rst)
    tc |-> (q == ALL_ONES && en_trk)); // R6

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int NUM_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          en_par,
  input  logic                          en_trk,
  input  logic [NUM_STAGES*STAGE_W-1:0] din,
  output logic [NUM_STAGES*STAGE_W-1:0] q,
  output logic                          tc_out
);

  localparam int TOTAL_W = NUM_STAGES * STAGE_W;

  logic [NUM_STAGES:0] trk;

  assign trk[0] = en_trk;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (trk[k]),
      .din    (din[k*STAGE_W +: STAGE_W]),
      .q      (q[k*STAGE_W +: STAGE_W]),
      .tc     (trk[k+1])
    );
  end

  assign tc_out = trk[NUM_STAGES];

  AST_CHAIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_par && en_trk && q == {TOTAL_W{1'b1}}) |=> q == '0); // R4
  AST_CHAIN_TC: assert property (@(posedge clk) disable iff (rst)
    tc_out |-> (en_trk && q == {TOTAL_W{1'b1}})); // R6

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int NUM_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          div_en,
  input  logic                          en_par,
  input  logic                          en_trk,
  input  logic [NUM_STAGES*STAGE_W-1:0] preset,
  output logic [NUM_STAGES*STAGE_W-1:0] count,
  output logic                          term_cnt
);

  logic load_eff_n;

  // Divider mode: the final terminal count forces a reload of the preset.
  assign load_eff_n = load_n && !(div_en && term_cnt);

  cnt_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .load_n (load_eff_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .din    (preset),
    .q      (count),
    .tc_out (term_cnt)
  );

  AST_DIV_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (div_en && clr_n && term_cnt) |=> count == $past(preset)); // R7
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (div_en && !clr_n && term_cnt) |=> count == '0); // R8

endmodule

// File: tb/casc_counter_bench.sv
module casc_counter_bench;

  localparam int N   = 3;
  localparam int W   = N * 4;
  localparam int MOD = 1 << W;
  localparam int MAXV = MOD - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, clr_n, load_n, div_en, en_par, en_trk;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         term_cnt;

  casc_counter #(.NUM_STAGES(N)) u_casc_counter (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .div_en(div_en),
    .en_par(en_par), .en_trk(en_trk), .preset(preset),
    .count(count), .term_cnt(term_cnt)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  int  mref  = 0;
  bit  seen_tc;
  bit  done  = 0;

  function automatic bit model_tc(input int v, input bit et);
    return (v == MAXV) && et;
  endfunction

  function automatic int model_next(input int v, input bit r, input bit c,
                                    input bit l, input bit d, input bit ep,
                                    input bit et, input int p);
    bit ld;
    ld = !l || (d && model_tc(v, et));
    if (r)             return 0;
    else if (!c)       return 0;
    else if (ld)       return p;
    else if (ep && et) return (v + 1) % MOD;
    else               return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit r, input bit c, input bit l, input bit d,
                       input bit ep, input bit et, input int p);
    rst = r; clr_n = c; load_n = l; div_en = d;
    en_par = ep; en_trk = et; preset = p[W-1:0];
  endtask

  // Inputs are set after a falling edge; check tc, cross one rising edge, check count.
  task automatic step(input string req);
    int nxt;
    #1;
    seen_tc = term_cnt;
    check({req, " R6 tc"}, int'(term_cnt), int'(model_tc(mref, en_trk)));
    nxt = model_next(mref, rst, clr_n, load_n, div_en, en_par, en_trk, int'(preset));
    @(posedge clk);
    @(negedge clk);
    mref = nxt;
    check(req, int'(count), mref);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic div_period(input int p);
    int k;
    drive(0, 1, 0, 0, 1, 1, p); step("R3 preset");
    drive(0, 1, 1, 1, 1, 1, p);
    k = 0;
    seen_tc = 0;
    while (!seen_tc && k <= MOD) begin step("R7 run"); k++; end
    k = 0;
    step("R7 run"); k++;
    while (!seen_tc && k <= MOD) begin step("R7 run"); k++; end
    check("R7 period", k, MOD - p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    drive(1, 1, 1, 0, 1, 1, 0);
    @(negedge clk);
    step("R1 reset");
    check("R1 reset state", int'(count), 0);

    // R3: load ignores both enables
    drive(0, 1, 0, 0, 0, 0, 'h5A3); step("R3 load en off");
    // R2: clear wins over load and enables
    drive(0, 0, 0, 0, 1, 1, 'h777); step("R2 clear over load");
    drive(0, 1, 0, 0, 1, 0, 'h0FE); step("R3 load");
    drive(0, 1, 1, 0, 1, 1, 0);     step("R4 count");
    drive(0, 1, 1, 0, 1, 1, 0);     step("R4 carry 0FF->100");
    check("R4 carry value", int'(count), 'h100);
    // R5: each enable low holds
    drive(0, 1, 1, 0, 0, 1, 0);     step("R5 en_par low");
    drive(0, 1, 1, 0, 1, 0, 0);     step("R5 en_trk low");
    check("R5 held", int'(count), 'h100);
    // R4 wrap and R6 tc gated by en_trk
    drive(0, 1, 0, 0, 1, 1, MAXV);  step("R3 load max");
    drive(0, 1, 1, 0, 1, 0, 0);     step("R6 tc masked");
    drive(0, 1, 1, 0, 1, 1, 0);     step("R4 wrap");
    check("R4 wrap value", int'(count), 0);
    // R8: clear beats divider reload
    drive(0, 1, 0, 0, 1, 1, MAXV);  step("R3 load max");
    drive(0, 0, 1, 1, 1, 1, 'h123); step("R8 clear in divider");
    // R1 mid-run
    drive(0, 1, 0, 0, 1, 1, 'h3C3); step("R3 load");
    drive(1, 0, 0, 1, 1, 1, 'h111); step("R1 reset mid");

    // R7 divider periods
    div_period(0);
    div_period('hF00);
    div_period('hFFE);
    div_period(MAXV);

    // Random mix against the model: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 4000; i++) begin
      bit d;
      d = ((i / 500) % 2) == 1;
      drive(($urandom % 256) == 0, ($urandom % 32) != 0, ($urandom % 16) != 0,
            d, ($urandom % 8) != 0, ($urandom % 8) != 0,
            (($urandom % 4) == 0) ? MAXV - ($urandom % 3) : int'($urandom % MOD));
      step("R4 R5 random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule